// File: doc/BRIEF.md
# Byte SPI Master Shifter

This block is the serial engine of an SPI master that moves one byte per transfer. When the host writes a byte into the data buffer while the engine is idle and enabled, the transfer begins on the next clock. No separate start command is needed. The byte leaves most significant bit first on the serial output. At the same time, eight bits are gathered from the serial input, and when the eighth bit ends they land in the same buffer register.

SCK has a selectable idle level. A second control chooses whether SCK pulses in the first or the second half of each bit. SDI can be captured at mid-bit or at the end of the bit, and this choice is independent of the clock shape. The bit time comes from a fixed divider of the system clock or from an external timer pulse.

The serial output can be switched off while shifting carries on. This lets the block act as a receive-only line monitor. Three sticky flags report the outcome of a transfer: completion, buffer full and write collision.

Top module: `spi_byte_master`

## Requirements
- R1: With `en` high and `busy` low, a `wr_stb` pulse starts a transfer at that clock edge. `busy` is high from the next cycle, and `sdo` carries bit 7 of the written byte from that same cycle.
- R2: Bit k of the byte, for k = 7 down to 0, is held on `sdo` for one whole bit time, and bits change only at bit boundaries.
- R3: While the engine is idle, `sck` equals `sck_idle_hi`. During a transfer, each bit is split into two equal halves. With `early_data` = 0, `sck` is at its active level (the opposite of idle) in the first half. With `early_data` = 1, `sck` is active in the second half, so the first bit is on `sdo` before the first `sck` edge.
- R4: With `smp_end` = 0, the received bit is the `sdi` value present in the last system clock cycle of the bit's first half. With `smp_end` = 1, it is the value present in the last cycle of the second half.
- R5: Bit time depends on `rate_sel`. Codes 0, 1 and 2 give 4, 16 and 64 system clocks per bit. Code 3 advances one half-bit per clock cycle in which `tmr_tick` is high, which is two ticks per bit. With code 3 and no ticks, the transfer does not advance.
- R6: The transfer ends at the edge that closes the eighth bit, which is 8 bit times after the start edge. At that edge the received byte (first received bit in bit 7) is loaded into `rd_data`, `done` and `full` are set, and `busy` drops.
- R7: With `sdo_en` = 0, `sdo` stays low. Reception, buffer loading and flags work exactly as with `sdo_en` = 1.
- R8: `done` and `full` stay set until cleared. `rd_stb` clears `full`, and `clr_done` clears `done`. `rd_data` changes only when a transfer completes.
- R9: A `wr_stb` while `busy` is high is ignored, so the transfer in progress and its timing are unchanged, and it sets `wcol`. `wcol` stays set until `clr_wcol` is pulsed.
- R10: With `en` low, `sck` sits at its idle level, a transfer in progress is abandoned (`busy` low, `sdo` low, no flags set), and `wr_stb` is ignored. A transfer started after re-enabling has full timing from its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable |
| sck_idle_hi | input | 1 | SCK idle level (1 = high) |
| early_data | input | 1 | 1: SCK active in second half of each bit |
| smp_end | input | 1 | 1: capture SDI at end of bit, 0: at mid-bit |
| rate_sel | input | 2 | Bit rate select (0: /4, 1: /16, 2: /64, 3: timer ticks) |
| sdo_en | input | 1 | Serial output enable |
| tmr_tick | input | 1 | External timer pulse, one half-bit per pulse in code 3 |
| wr_stb | input | 1 | Host write of the transmit byte |
| wr_data | input | W | Transmit byte |
| rd_stb | input | 1 | Host read of the buffer, clears `full` |
| clr_done | input | 1 | Clears the completion flag |
| clr_wcol | input | 1 | Clears the write collision flag |
| rd_data | output | W | Buffer register with last received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| full | output | 1 | Buffer holds unread data |
| wcol | output | 1 | Sticky write collision flag |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The sample point is the hardest thing to see from the ports. A steady input gives the same byte whether it is captured at mid-bit or at the end of the bit. The stimulus therefore drives `sdi` from a cycle counter that starts at the write edge, with one pattern in the first half of every bit and a different pattern in the second half. The received byte then shows which half was captured. Collisions and aborts are forced at chosen cycles inside a running transfer. The transmit bits that follow and the exact completion cycle are then compared with a transfer that was not disturbed.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    RATE_D0  = 2'd0,
    RATE_D1  = 2'd1,
    RATE_D2  = 2'd2,
    RATE_TMR = 2'd3
  } rate_e;
endpackage

// File: rtl/spim_rate.sv
// Half-bit tick generator: fixed divider or external timer pulse.
module spim_rate
  import spim_pkg::*;
#(
  parameter int DIV0 = 4,
  parameter int DIV1 = 16,
  parameter int DIV2 = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_e sel,
  input  logic  tmr_tick,
  output logic  half_tick
);
  localparam int CW = $clog2(DIV2) + 1;
  localparam logic [CW-1:0] LIM0 = CW'(DIV0 / 2 - 1);
  localparam logic [CW-1:0] LIM1 = CW'(DIV1 / 2 - 1);
  localparam logic [CW-1:0] LIM2 = CW'(DIV2 / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    case (sel)
      RATE_D0: lim = LIM0;
      RATE_D1: lim = LIM1;
      default: lim = LIM2;
    endcase
    if (sel == RATE_TMR) half_tick = run & tmr_tick;
    else                 half_tick = run & (cnt_q >= lim);
    cnt_d = cnt_q;
    if (!run || half_tick)  cnt_d = '0;
    else if (sel != RATE_TMR) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Fastest divider: ticks never fall on consecutive cycles.
  p_fast_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && sel == RATE_D0) |=> (!half_tick || sel != RATE_D0));
endmodule

// File: rtl/spim_shift.sv
// Bit sequencer, shift register, sampling and SCK shaping.
module spim_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic [W-1:0] tx_byte,
  input  logic         half_tick,
  input  logic         cpol,
  input  logic         early,
  input  logic         smp_end,
  input  logic         sdi,
  output logic         busy,
  output logic         sck,
  output logic         msb,
  output logic         done_pulse,
  output logic [W-1:0] rx_byte
);
  localparam int BCW = (W > 2) ? $clog2(W) : 1;
  localparam logic [BCW-1:0] LAST = BCW'(W - 1);

  logic           busy_q, busy_d;
  logic           ph_q, ph_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic [W-1:0]   sr_q, sr_d;
  logic           smp_q, smp_d;
  logic           bit_end, in_bit;

  always_comb begin
    in_bit     = smp_end ? sdi : smp_q;
    bit_end    = busy_q & half_tick & ph_q;
    done_pulse = bit_end & (bit_q == LAST);
    rx_byte    = {sr_q[W-2:0], in_bit};
    busy_d = busy_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    sr_d   = sr_q;
    smp_d  = smp_q;
    if (!en) begin
      busy_d = 1'b0;
      ph_d   = 1'b0;
      bit_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      ph_d   = 1'b0;
      bit_d  = '0;
      sr_d   = tx_byte;
    end else if (busy_q && half_tick) begin
      if (!ph_q) begin
        ph_d = 1'b1;
        if (!smp_end) smp_d = sdi;
      end else begin
        ph_d = 1'b0;
        sr_d = rx_byte;
        if (done_pulse) begin
          busy_d = 1'b0;
          bit_d  = '0;
        end else begin
          bit_d = bit_q + BCW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      bit_q  <= '0;
      sr_q   <= '0;
      smp_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sr_q   <= sr_d;
      smp_q  <= smp_d;
    end
  end

  assign busy = busy_q;
  assign msb  = sr_q[W-1];
  assign sck  = busy_q ? (cpol ^ (early ? ph_q : ~ph_q)) : cpol;

  // Transmit bit holds for the whole bit time.
  p_msb_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bit_end && !start) |=> (!busy_q || $stable(sr_q[W-1])));
  // SCK only moves on a half-bit tick (configuration held).
  p_sck_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !half_tick && en) |=>
      ($stable(sck) || !$stable(cpol) || !$stable(early)));
  // After the last bit the engine is idle with SCK at rest.
  p_end_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && en) |=> (!busy_q && sck == cpol));
endmodule

// File: rtl/spim_stat.sv
// Receive buffer and sticky status flags.
module spim_stat #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] rx_byte,
  input  logic         wr_stb,
  input  logic         busy,
  input  logic         rd_stb,
  input  logic         clr_done,
  input  logic         clr_wcol,
  output logic [W-1:0] buf_data,
  output logic         done,
  output logic         full,
  output logic         wcol
);
  logic [W-1:0] buf_q, buf_d;
  logic done_q, done_d, full_q, full_d, wcol_q, wcol_d, collide;

  always_comb begin
    collide = wr_stb & en & busy;
    buf_d   = load ? rx_byte : buf_q;
    done_d  = load | (done_q & ~clr_done);
    full_d  = load | (full_q & ~rd_stb);
    wcol_d  = collide | (wcol_q & ~clr_wcol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      done_q <= 1'b0;
      full_q <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      done_q <= done_d;
      full_q <= full_d;
      wcol_q <= wcol_d;
    end
  end

  assign buf_data = buf_q;
  assign done     = done_q;
  assign full     = full_q;
  assign wcol     = wcol_q;

  p_full_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (full_q && done_q));
  p_buf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(buf_q));
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_done) |=> done_q);
  p_wcol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && busy && en) |=> wcol_q);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spim_pkg::*;
#(
  parameter int W    = 8,
  parameter int DIV0 = 4,
  parameter int DIV1 = 16,
  parameter int DIV2 = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sck_idle_hi,
  input  logic         early_data,
  input  logic         smp_end,
  input  logic [1:0]   rate_sel,
  input  logic         sdo_en,
  input  logic         tmr_tick,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         rd_stb,
  input  logic         clr_done,
  input  logic         clr_wcol,
  output logic [W-1:0] rd_data,
  output logic         busy,
  output logic         done,
  output logic         full,
  output logic         wcol,
  output logic         sck,
  output logic         sdo,
  input  logic         sdi
);
  logic         half_tick, start, msb, done_pulse, busy_i;
  logic [W-1:0] rx_byte;

  assign start = wr_stb & en & ~busy_i;

  spim_rate #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_i),
    .sel      (rate_e'(rate_sel)),
    .tmr_tick (tmr_tick),
    .half_tick(half_tick)
  );

  spim_shift #(.W(W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .start     (start),
    .tx_byte   (wr_data),
    .half_tick (half_tick),
    .cpol      (sck_idle_hi),
    .early     (early_data),
    .smp_end   (smp_end),
    .sdi       (sdi),
    .busy      (busy_i),
    .sck       (sck),
    .msb       (msb),
    .done_pulse(done_pulse),
    .rx_byte   (rx_byte)
  );

  spim_stat #(.W(W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .load    (done_pulse & en),
    .rx_byte (rx_byte),
    .wr_stb  (wr_stb),
    .busy    (busy_i),
    .rd_stb  (rd_stb),
    .clr_done(clr_done),
    .clr_wcol(clr_wcol),
    .buf_data(rd_data),
    .done    (done),
    .full    (full),
    .wcol    (wcol)
  );

  assign busy = busy_i;
  assign sdo  = busy_i & sdo_en & msb;

  // Output is silent whenever the driver is switched off.
  p_sdo_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en |-> !sdo);
  // A write while idle and enabled always launches a transfer.
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && en && !busy) |=> (busy || !en));
endmodule

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
  logic clk = 1'b0;
  logic rst_n, en, cpol, early, smp_end, sdo_en, tmr_tick;
  logic wr_stb, rd_stb, clr_done, clr_wcol, sdi;
  logic [1:0] rate_sel;
  logic [7:0] wr_data, rd_data;
  logic busy, done, full, wcol, sck, sdo;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  spi_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .sck_idle_hi(cpol), .early_data(early),
    .smp_end(smp_end), .rate_sel(rate_sel), .sdo_en(sdo_en), .tmr_tick(tmr_tick),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .clr_done(clr_done),
    .clr_wcol(clr_wcol), .rd_data(rd_data), .busy(busy), .done(done), .full(full),
    .wcol(wcol), .sck(sck), .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk);
    rd_stb = 1'b1; clr_done = 1'b1; clr_wcol = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; clr_done = 1'b0; clr_wcol = 1'b0;
  endtask

  // One divided-rate transfer driven from a cycle count since the write edge.
  task automatic do_xfer(input logic [7:0] tx, input logic [7:0] pa,
                         input logic [7:0] pb, input logic [1:0] rs, input int h,
                         input logic pol, input logic ld, input logic late,
                         input logic oe, input int col_at);
    int sck_bad = 0, sdo_bad = 0, sck_a = 0, sck_e = 0, sdo_a = 0, sdo_e = 0;
    logic [7:0] exp_rx;
    exp_rx = late ? pb : pa;
    @(negedge clk);
    cpol = pol; early = ld; smp_end = late; sdo_en = oe; rate_sel = rs;
    wr_data = tx; wr_stb = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 16 * h; c++) begin
      int b;
      bit hf;
      logic es, eo;
      if (c > 0) @(negedge clk);
      b  = c / (2 * h);
      hf = (c % (2 * h)) >= h;
      sdi = hf ? pb[7-b] : pa[7-b];
      wr_stb = (c == col_at);
      wr_data = ~tx;
      es = pol ^ (ld ? hf : !hf);
      eo = oe ? tx[7-b] : 1'b0;
      if (sck !== es && sck_bad == 0) begin sck_a = sck; sck_e = es; end
      if (sck !== es) sck_bad++;
      if (sdo !== eo && sdo_bad == 0) begin sdo_a = sdo; sdo_e = eo; end
      if (sdo !== eo) sdo_bad++;
      if (c == 0) chk(busy === 1'b1, "R1", "busy after write", busy, 1);
      if (col_at >= 0 && c == col_at + 1)
        chk(wcol === 1'b1, "R9", "wcol after write while busy", wcol, 1);
      if (c == 16 * h - 1) chk(done === 1'b0, "R6", "done before last edge", done, 0);
    end
    chk(sck_bad == 0, "R3", "sck shape", sck_a, sck_e);
    chk(sdo_bad == 0, oe ? "R2" : "R7", "sdo bits", sdo_a, sdo_e);
    @(negedge clk);
    wr_stb = 1'b0;
    chk(done === 1'b1 && full === 1'b1 && busy === 1'b0, "R6", "flags at end",
        {done, full, busy}, 3'b110);
    chk(rd_data === exp_rx, late ? "R4" : "R4", late ? "rx end-sample" : "rx mid-sample",
        rd_data, exp_rx);
    chk(sck === pol, "R3", "sck idle after", sck, pol);
  endtask

  task automatic t_reset();
    chk(busy === 0 && done === 0 && full === 0 && wcol === 0, "R6", "reset flags",
        {busy, done, full, wcol}, 0);
    chk(sck === 1'b0 && sdo === 1'b0, "R3", "reset sck/sdo", {sck, sdo}, 0);
  endtask

  task automatic t_mid();  // R4 mid-bit, R5 /4
    do_xfer(8'hB4, 8'h6D, 8'h92, 2'd0, 2, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    clear_flags();
  endtask

  task automatic t_late();
    do_xfer(8'h5A, 8'h13, 8'hE8, 2'd0, 2, 1'b1, 1'b1, 1'b1, 1'b1, -1);
    clear_flags();
  endtask

  task automatic t_rates();  // R5 /16 and /64 with exact end cycle
    do_xfer(8'hC3, 8'hA1, 8'h1E, 2'd1, 8, 1'b0, 1'b1, 1'b0, 1'b1, -1);
    clear_flags();
    do_xfer(8'h27, 8'h4B, 8'hF0, 2'd2, 32, 1'b1, 1'b0, 1'b1, 1'b1, -1);
    clear_flags();
  endtask

  task automatic t_monitor();  // R7
    do_xfer(8'hFF, 8'h99, 8'h66, 2'd0, 2, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    clear_flags();
  endtask

  task automatic t_collision();  // R9
    do_xfer(8'hA5, 8'h3C, 8'h00, 2'd0, 2, 1'b0, 1'b1, 1'b0, 1'b1, 5);
    chk(wcol === 1'b1, "R9", "wcol sticky", wcol, 1);
    clear_flags();
    chk(wcol === 1'b0, "R9", "wcol cleared", wcol, 0);
  endtask

  task automatic t_timer();  // R5 timer ticks
    logic [7:0] pat = 8'h5C;
    int moved = 0;
    @(negedge clk);
    cpol = 1'b0; early = 1'b0; smp_end = 1'b0; sdo_en = 1'b1; rate_sel = 2'd3;
    tmr_tick = 1'b0; wr_data = 8'h81; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sck !== 1'b1 || busy !== 1'b1) moved++;
    end
    chk(moved == 0, "R5", "no progress without ticks", moved, 0);
    for (int p = 0; p < 16; p++) begin
      sdi = pat[7 - p / 2];
      tmr_tick = 1'b1;
      @(negedge clk);
      tmr_tick = 1'b0;
      if (p == 14) chk(done === 1'b0, "R5", "done before 16th tick", done, 0);
      if (p == 15) chk(done === 1'b1, "R5", "done at 16th tick", done, 1);
      @(negedge clk);
      @(negedge clk);
    end
    chk(rd_data === pat, "R5", "timer rx", rd_data, pat);
    clear_flags();
  endtask

  task automatic t_flags();  // R8
    do_xfer(8'h0F, 8'hD2, 8'h2D, 2'd0, 2, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    repeat (5) @(negedge clk);
    chk(done === 1'b1 && full === 1'b1, "R8", "flags held", {done, full}, 2'b11);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk(full === 1'b0 && done === 1'b1, "R8", "read clears full", {done, full}, 2'b10);
    clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
    chk(done === 1'b0 && rd_data === 8'hD2, "R8", "clr_done, data kept",
        {done, rd_data}, {1'b0, 8'hD2});
  endtask

  task automatic t_enable();  // R10
    @(negedge clk);
    en = 1'b0; cpol = 1'b1; rate_sel = 2'd0; sdo_en = 1'b1; wr_data = 8'hFF; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(busy === 1'b0 && sck === 1'b1, "R10", "write ignored when off", {busy, sck}, 2'b01);
    en = 1'b1; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    repeat (6) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && sck === 1'b1 && sdo === 1'b0, "R10", "abort",
        {busy, sck, sdo}, 3'b010);
    repeat (40) @(negedge clk);
    chk(done === 1'b0 && full === 1'b0, "R10", "no flags after abort", {done, full}, 0);
    en = 1'b1;
    do_xfer(8'h96, 8'h71, 8'h8E, 2'd0, 2, 1'b1, 1'b0, 1'b0, 1'b1, -1);
    clear_flags();
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; cpol = 1'b0; early = 1'b0; smp_end = 1'b0;
    sdo_en = 1'b1; tmr_tick = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
    clr_done = 1'b0; clr_wcol = 1'b0; sdi = 1'b0; rate_sel = 2'd0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_mid();
    t_late();
    t_rates();
    t_monitor();
    t_collision();
    t_timer();
    t_flags();
    t_enable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule